// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a single-cycle packed integer arithmetic unit with a 64-bit datapath. Each operand is viewed as eight bytes, four words, two double words or one quad word, chosen by a lane-size input. The unit applies the same operation to every lane at once. Lanes stay fully independent: no carry, borrow or shifted-out bit crosses from one lane into the next.

The operations are wrapping add and subtract, saturating add and subtract in signed and unsigned forms, equality and signed greater-than compares that return whole-lane masks, four bitwise operations, and per-lane logical and arithmetic shifts driven by a separate count input. Only some pairings of operation and lane size are defined. Any other pairing returns zero and raises an error flag.

The result is registered, so an operation presented with `in_valid` high appears at the outputs one clock later with `out_valid` set. When `in_valid` is low, the registered result and error flag hold their previous values.

Top module: `simd_alu`

## Requirements
- R1: After reset `out_valid`, `result` and `err` are zero. `out_valid` equals `in_valid` delayed by one clock, and the result of an accepted operation appears on the edge that follows its acceptance.
- R2: Lane size codes are 0 byte, 1 word, 2 double word, 3 quad word. Op 0 is a wrapping add for all four sizes. Op 3 is a wrapping subtract a-b for byte, word and double word. No carry or borrow passes between lanes.
- R3: Op 1 is a signed saturating add and op 4 a signed saturating subtract, for byte and word lanes. A result that overflows clamps to the lane's most positive or most negative value.
- R4: Op 2 is an unsigned saturating add and op 5 an unsigned saturating subtract, for byte and word lanes. An add clamps to all ones and a subtract clamps to zero.
- R5: Op 6 compares a and b for equality per byte, word or double word lane. The lane becomes all ones when they are equal and all zeros otherwise.
- R6: Op 7 compares a > b as signed values per byte, word or double word lane. The lane becomes all ones when the condition holds and all zeros otherwise.
- R7: Ops 8, 9, 10 and 11 give a AND b, (NOT a) AND b, a OR b and a XOR b. These ops are legal at every lane size, and the size has no effect on their result.
- R8: Op 12 shifts left and op 13 shifts right logically, for word, double word and quad word lanes. A count of at least the lane width gives zero.
- R9: Op 14 shifts right arithmetically, for word and double word lanes. A count of at least the lane width fills the lane with its sign bit.
- R10: An op and size pairing that none of R2 to R9 lists, and op 15, gives a zero result with `err` high. Every legal pairing gives `err` low.
- R11: While `in_valid` is low, `result` and `err` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_i | input | 4 | Operation code |
| lane_i | input | 2 | Lane size code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cnt_i | input | 8 | Shift count, shared by all lanes |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered packed result |
| err_o | output | 1 | Illegal op and size pairing |

## Verification
Every result, the error flag and `out_valid` are due exactly one rising edge after `in_valid` is sampled high. The bench drives inputs on a falling edge and compares the outputs on the next falling edge, half a period after the register has loaded. Hold behaviour is checked the same way: one edge with `in_valid` low must leave `result` and `err` unchanged. Directed cases cover saturation at both limits, carries at lane edges, shift counts at and beyond the lane width, and illegal pairings. Seeded random operations, including illegal ones, are compared against a lane-by-lane reference function.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int DATA_W = 64;
    localparam int NBYTES = DATA_W / 8;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_ADDUS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBS  = 4'd4,
        OP_SUBUS = 4'd5,
        OP_CMPEQ = 4'd6,
        OP_CMPGT = 4'd7,
        OP_AND   = 4'd8,
        OP_ANDN  = 4'd9,
        OP_OR    = 4'd10,
        OP_XOR   = 4'd11,
        OP_SLL   = 4'd12,
        OP_SRL   = 4'd13,
        OP_SRA   = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LS_B = 2'd0,
        LS_W = 2'd1,
        LS_D = 2'd2,
        LS_Q = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] res;
    } alu_state_s;

    function automatic logic pair_legal(alu_op_e op, lane_sz_e sz);
        case (op)
            OP_ADD:                             return 1'b1;
            OP_SUB, OP_CMPEQ, OP_CMPGT:         return sz != LS_Q;
            OP_ADDS, OP_ADDUS, OP_SUBS, OP_SUBUS: return sz == LS_B || sz == LS_W;
            OP_AND, OP_ANDN, OP_OR, OP_XOR:     return 1'b1;
            OP_SLL, OP_SRL:                     return sz != LS_B;
            OP_SRA:                             return sz == LS_W || sz == LS_D;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic bytes_ge(logic [DATA_W-1:0] r, logic [DATA_W-1:0] a);
        for (int i = 0; i < NBYTES; i++)
            if (r[i*8 +: 8] < a[i*8 +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic bytes_mask(logic [DATA_W-1:0] r);
        for (int i = 0; i < NBYTES; i++)
            if (r[i*8 +: 8] != 8'h00 && r[i*8 +: 8] != 8'hFF) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_alu_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic [NB*8-1:0] a,
    input  logic [NB*8-1:0] b,
    input  logic            sub,
    input  logic            sat_en,
    input  logic            sat_signed,
    input  lane_sz_e        sz,
    output logic [NB*8-1:0] y
);
    logic [NB-1:0] co;
    logic [7:0]    raw [NB];
    logic [7:0]    bx  [NB];

    always_comb begin
        int lmask;
        lmask = (1 << int'(sz)) - 1;
        for (int i = 0; i < NB; i++) begin
            logic cin;
            bx[i] = b[i*8 +: 8] ^ {8{sub}};
            if ((i & lmask) == 0) cin = sub;
            else                  cin = co[i-1];
            {co[i], raw[i]} = {1'b0, a[i*8 +: 8]} + {1'b0, bx[i]} + {8'd0, cin};
        end
    end

    always_comb begin
        int lmask;
        lmask = (1 << int'(sz)) - 1;
        for (int i = 0; i < NB; i++) begin
            int   top;
            logic as, bs, rs, sovf, uovf;
            top  = i | lmask;
            as   = a[top*8 + 7];
            bs   = bx[top][7];
            rs   = raw[top][7];
            sovf = (as == bs) && (rs != as);
            uovf = sub ? !co[top] : co[top];
            if (sat_en && sat_signed && sovf) begin
                if (i == top) y[i*8 +: 8] = as ? 8'h80 : 8'h7F;
                else          y[i*8 +: 8] = as ? 8'h00 : 8'hFF;
            end else if (sat_en && !sat_signed && uovf) begin
                y[i*8 +: 8] = sub ? 8'h00 : 8'hFF;
            end else begin
                y[i*8 +: 8] = raw[i];
            end
        end
    end
endmodule

// File: rtl/simd_cmp.sv
module simd_cmp
    import simd_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_gt,
    input  lane_sz_e      sz,
    output logic [DW-1:0] y
);
    logic [DW-1:0] by_sz [3];

    for (genvar g = 0; g < 3; g++) begin : g_size
        localparam int W = 8 << g;
        for (genvar l = 0; l < DW / W; l++) begin : g_lane
            logic hit;
            assign hit = is_gt ? ($signed(a[l*W +: W]) > $signed(b[l*W +: W]))
                               : (a[l*W +: W] == b[l*W +: W]);
            assign by_sz[g][l*W +: W] = hit ? {W{1'b1}} : {W{1'b0}};
        end
    end

    always_comb begin
        case (sz)
            LS_B:    y = by_sz[0];
            LS_W:    y = by_sz[1];
            LS_D:    y = by_sz[2];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_shift.sv
module simd_shift
    import simd_alu_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CNT_W = 8
) (
    input  logic [DW-1:0]    a,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       mode,
    input  lane_sz_e         sz,
    output logic [DW-1:0]    y
);
    logic [DW-1:0] by_sz [3];

    for (genvar g = 0; g < 3; g++) begin : g_size
        localparam int W = 16 << g;
        localparam logic [CNT_W-1:0] WLIM = CNT_W'(W);
        for (genvar l = 0; l < DW / W; l++) begin : g_lane
            logic [W-1:0] x, sl, sr, sa;
            logic         big;
            assign x   = a[l*W +: W];
            assign big = cnt >= WLIM;
            assign sl  = big ? '0 : (x << cnt);
            assign sr  = big ? '0 : (x >> cnt);
            assign sa  = big ? {W{x[W-1]}} : W'($signed(x) >>> cnt);
            assign by_sz[g][l*W +: W] = (mode == 2'd0) ? sl :
                                        (mode == 2'd1) ? sr : sa;
        end
    end

    always_comb begin
        case (sz)
            LS_W:    y = by_sz[0];
            LS_D:    y = by_sz[1];
            LS_Q:    y = by_sz[2];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_i,
    input  logic [1:0]        lane_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              err_o
);
    alu_op_e    op;
    lane_sz_e   sz;
    alu_state_s st_d, st_q;
    logic [DATA_W-1:0] as_y, cmp_y, sh_y;
    logic sub_sel, sat_sel, sgn_sel, legal;
    logic [1:0] sh_mode;

    assign op      = alu_op_e'(op_i);
    assign sz      = lane_sz_e'(lane_i);
    assign legal   = pair_legal(op, sz);
    assign sub_sel = op inside {OP_SUB, OP_SUBS, OP_SUBUS};
    assign sat_sel = op inside {OP_ADDS, OP_ADDUS, OP_SUBS, OP_SUBUS};
    assign sgn_sel = op inside {OP_ADDS, OP_SUBS};
    assign sh_mode = (op == OP_SLL) ? 2'd0 : (op == OP_SRL) ? 2'd1 : 2'd2;

    simd_addsub #(.NB(NBYTES)) u_addsub (
        .a(a_i), .b(b_i), .sub(sub_sel), .sat_en(sat_sel),
        .sat_signed(sgn_sel), .sz(sz), .y(as_y)
    );

    simd_cmp #(.DW(DATA_W)) u_cmp (
        .a(a_i), .b(b_i), .is_gt(op == OP_CMPGT), .sz(sz), .y(cmp_y)
    );

    simd_shift #(.DW(DATA_W), .CNT_W(CNT_W)) u_shift (
        .a(a_i), .cnt(cnt_i), .mode(sh_mode), .sz(sz), .y(sh_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.err = !legal;
            st_d.res = '0;
            if (legal) begin
                case (op)
                    OP_AND:                   st_d.res = a_i & b_i;
                    OP_ANDN:                  st_d.res = ~a_i & b_i;
                    OP_OR:                    st_d.res = a_i | b_i;
                    OP_XOR:                   st_d.res = a_i ^ b_i;
                    OP_CMPEQ, OP_CMPGT:       st_d.res = cmp_y;
                    OP_SLL, OP_SRL, OP_SRA:   st_d.res = sh_y;
                    default:                  st_d.res = as_y;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;
    assign err_o       = st_q.err;

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);
    p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid_o);
    p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> result_o == '0);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_o) && $stable(err_o));
    p_usat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADDUS && sz == LS_B) |=> bytes_ge(result_o, $past(a_i)));
    p_cmp_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CMPEQ || op == OP_CMPGT)) |=> bytes_mask(result_o));
    p_sra_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SRA && legal) |=> result_o[DATA_W-1] == $past(a_i[DATA_W-1]));
endmodule

// File: tb/simd_alu_test.sv
`timescale 1ns/1ps
module simd_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  lane_i = '0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [7:0]  cnt_i = '0;
    logic        out_valid_o, err_o;
    logic [63:0] result_o;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    simd_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .lane_i(lane_i), .a_i(a_i), .b_i(b_i), .cnt_i(cnt_i),
        .out_valid_o(out_valid_o), .result_o(result_o), .err_o(err_o)
    );

    function automatic bit ok_pair(int op, int sz);
        case (op)
            0, 8, 9, 10, 11: return 1;
            3, 6, 7:         return sz != 3;
            1, 2, 4, 5:      return sz <= 1;
            12, 13:          return sz >= 1;
            14:              return sz == 1 || sz == 2;
            default:         return 0;
        endcase
    endfunction

    function automatic longint sx_of(logic [63:0] x, int w);
        if (w == 64) return $signed(x);
        if (x[w-1]) return longint'(x) - (longint'(1) << w);
        return longint'(x);
    endfunction

    function automatic logic [64:0] model(int op, int sz, logic [63:0] a, logic [63:0] b, int cnt);
        int w = 8 << sz;
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
        logic [63:0] res = '0;
        longint lo = -(longint'(1) << (w - 1));
        longint hi = (longint'(1) << (w - 1)) - 1;
        if (!ok_pair(op, sz)) return {1'b1, 64'd0};
        case (op)
            8:  return {1'b0, a & b};
            9:  return {1'b0, ~a & b};
            10: return {1'b0, a | b};
            11: return {1'b0, a ^ b};
            default: ;
        endcase
        for (int l = 0; l < 64 / w; l++) begin
            logic [63:0] x = (a >> (l*w)) & m;
            logic [63:0] y = (b >> (l*w)) & m;
            longint sa = sx_of(x, w), sb = sx_of(y, w), s;
            logic [63:0] r;
            case (op)
                0: r = x + y;
                3: r = x - y;
                1, 4: begin
                    s = (op == 1) ? sa + sb : sa - sb;
                    if (s > hi) s = hi;
                    if (s < lo) s = lo;
                    r = 64'(s);
                end
                2: r = (x + y > m) ? m : x + y;
                5: r = (x < y) ? 64'd0 : x - y;
                6: r = (x == y) ? m : 64'd0;
                7: r = (sa > sb) ? m : 64'd0;
                12: r = (cnt >= w) ? 64'd0 : (x << cnt);
                13: r = (cnt >= w) ? 64'd0 : (x >> cnt);
                default: r = (cnt >= w) ? ((sa < 0) ? m : 64'd0) : 64'(sa >>> cnt);
            endcase
            res |= (r & m) << (l*w);
        end
        return {1'b0, res};
    endfunction

    function automatic string tag_of(int op, int sz);
        if (!ok_pair(op, sz)) return "R10";
        case (op)
            0, 3: return "R2";
            1, 4: return "R3";
            2, 5: return "R4";
            6: return "R5";
            7: return "R6";
            8, 9, 10, 11: return "R7";
            12, 13: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(int op, int sz, logic [63:0] a, logic [63:0] b, int cnt, string tag);
        logic [64:0] e;
        @(negedge clk);
        in_valid = 1'b1; op_i = 4'(op); lane_i = 2'(sz);
        a_i = a; b_i = b; cnt_i = 8'(cnt);
        e = model(op, sz, a, b, cnt);
        @(negedge clk);
        check(tag, result_o, e[63:0]);
        check(tag, {63'd0, err_o}, {63'd0, e[64]});
        check("R1", {63'd0, out_valid_o}, 64'd1);
    endtask

    task automatic idle_check();
        logic [63:0] r0 = result_o;
        logic e0 = err_o;
        @(negedge clk);
        in_valid = 1'b0; op_i = 4'd15; a_i = ~a_i; b_i = ~b_i;
        @(negedge clk);
        check("R11", result_o, r0);
        check("R11", {63'd0, err_o}, {63'd0, e0});
        check("R1", {63'd0, out_valid_o}, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check("R1", {result_o[63:1], out_valid_o ^ result_o[0], err_o}, 64'd0);
        rst_n = 1'b1;
        // R2 wrapping with lane isolation
        run_op(0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, "R2");
        run_op(0, 3, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, "R2");
        run_op(3, 1, 64'h0000_0005_8000_0001, 64'h0001_0006_0001_0002, 0, "R2");
        // R3 signed saturation
        run_op(1, 0, 64'h7F80_0000_0000_0000, 64'h0180_0000_0000_0000, 0, "R3");
        run_op(4, 1, 64'h8000_7FFF_0000_0000, 64'h0001_FFFF_0000_0000, 0, "R3");
        // R4 unsigned saturation
        run_op(2, 0, 64'hFF10_0000_0000_0000, 64'h01F0_0000_0000_0000, 0, "R4");
        run_op(5, 1, 64'h0000_0005_0000_0000, 64'h0001_0003_0000_0000, 0, "R4");
        // R5 / R6 compares
        run_op(6, 2, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, 0, "R5");
        run_op(7, 0, 64'h807F_0000_0000_0000, 64'h7F80_0000_0000_0000, 0, "R6");
        // R7 logic, lane size ignored
        run_op(9, 3, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF, 0, "R7");
        run_op(9, 0, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF, 0, "R7");
        // R8 / R9 shifts at and beyond the lane width
        run_op(12, 1, 64'h8001_8001_8001_8001, 0, 16, "R8");
        run_op(13, 3, 64'h8000_0000_0000_0000, 0, 63, "R8");
        run_op(14, 2, 64'h8000_0000_7FFF_FFFF, 0, 40, "R9");
        run_op(14, 1, 64'h8000_4000_F000_0F00, 0, 4, "R9");
        // R10 illegal pairings
        run_op(1, 2, 64'h1, 64'h1, 0, "R10");
        run_op(15, 0, 64'h1, 64'h1, 0, "R10");
        idle_check();
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 15);
            int sz = $urandom_range(0, 3);
            int c  = $urandom_range(0, 70);
            run_op(op, sz, {$urandom, $urandom}, {$urandom, $urandom}, c, tag_of(op, sz));
            if (k % 50 == 0) idle_check();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule